// File: doc/BRIEF.md
# Dual-Channel IDE Card Host Register Decoder

This block is the host-facing register decoder of a two-channel IDE expansion card. The host reaches it through single-byte reads and writes, each raised as a request and answered by a one-cycle acknowledge. The block splits the host address into several windows. Each channel has a taskfile window and an alternate control register, both forwarded to that channel's drive port through chip selects, a register index and read/write strobes. Each channel also has an interrupt enable port and an interrupt status byte. A 4-bit card identity is spread one bit per word, and a select register sits at offset zero.

The select register does two jobs. It steers the DMA request/acknowledge pair to one of the two drive ports, and it opens the extended window through which all channel resources are reached. While that window is closed, only the identity bits and the select register answer. Each channel's interrupt enable is set by any write to its enable port and cleared by any read of the same port. The card interrupt output is the registered OR, over both channels, of enable AND drive interrupt.

Host accesses run through a four-state sequencer. `ST_IDLE` accepts a request. A register hit moves `ST_IDLE -> ST_ACK`. A taskfile or alternate control hit moves `ST_IDLE -> ST_SETUP -> ST_STROBE -> ST_ACK`: the chip select alone is driven in `ST_SETUP`, the read or write strobe is added in `ST_STROBE`, and read data is captured at the end of `ST_STROBE`. `ST_ACK` always returns to `ST_IDLE`. Any side effect of an access (select load, enable set or clear) takes effect on the accepting clock edge.

Top module: `ide_card_decoder`

## Requirements
- R1: After reset the select register reads 0x00, both interrupt enables are clear, `card_irq` is 0, and no chip select, strobe or acknowledge is active.
- R2: A write to offset 0x0000 loads the select register from data bits 0 (DMA channel) and 5 (extended window). A read of offset 0x0000 returns those two bits in the same positions, with all other bits 0.
- R3: While the extended window is closed, reading 0x2280 + 4*i (i = 0..3) returns bit i of the card type (3) in bit 0, with bits 7..1 at 0. While the window is open, these offsets read 0xFF.
- R4: While the extended window is closed, every channel offset other than the identity words reads 0xFF, and writes to them change no interrupt enable and assert no chip select.
- R5: With the window open, any write to 0x2200 (channel 0) or 0x3200 (channel 1) sets that channel's interrupt enable. Any read of the same offset clears it and returns 0x00.
- R6: With the window open, reading 0x2290 or 0x3290 returns that channel's drive interrupt input in bit 0, with bits 7..1 at 0.
- R7: `card_irq` equals the OR over both channels of (enable AND `drv_intrq`), registered one clock later.
- R8: With the window open, offset base + 64*n (base 0x2000 for channel 0, 0x3000 for channel 1, n = 0..7) drives that channel's `ide_cs_tf` bit with `ide_da` = n. The chip select alone is driven for one cycle, then it is held together with `ide_rd` or `ide_wr` for one cycle, and read data is taken from that channel's `ide_din`.
- R9: With the window open, offset base + 0x380 accesses the alternate control register through that channel's `ide_cs_alt` bit with `ide_da` = 6, using the same setup/strobe sequence.
- R10: Select bit 0 = 0 routes `drv_dmarq[0]` to `host_dmarq` and `host_dmack` to `drv_dmack[0]`. Bit 0 = 1 routes channel 1 instead. The unselected `drv_dmack` bit stays 0.
- R11: Unmapped offsets, including taskfile offsets that are not a multiple of 64, read 0xFF and have no side effect.
- R12: `host_ack` is a single-cycle pulse. It comes one cycle after the accepting edge for register hits and unmapped offsets, and three cycles after it for taskfile and alternate control hits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Access request, accepted in idle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Byte offset into the card space |
| host_wdata | input | 8 | Write data |
| host_ack | output | 1 | One-cycle access completion |
| host_rdata | output | 8 | Read data, valid with `host_ack` |
| card_irq | output | 1 | Combined card interrupt |
| drv_intrq | input | 2 | Drive interrupt per channel |
| drv_dmarq | input | 2 | Drive DMA request per channel |
| host_dmarq | output | 1 | Routed DMA request toward the host |
| host_dmack | input | 1 | DMA acknowledge from the host |
| drv_dmack | output | 2 | Routed DMA acknowledge per channel |
| ide_cs_tf | output | 2 | Taskfile chip select per channel |
| ide_cs_alt | output | 2 | Alternate control chip select per channel |
| ide_da | output | 3 | Drive register index |
| ide_rd | output | 1 | Drive read strobe |
| ide_wr | output | 1 | Drive write strobe |
| ide_dout | output | 8 | Write data toward the drives |
| ide_din0 | input | 8 | Read data from channel 0 |
| ide_din1 | input | 8 | Read data from channel 1 |

## Verification
A vector table reads the select register, the identity words, the status bytes and several unmapped or misaligned offsets, once with the extended window closed and once with it open. These reads tell window gating apart from plain decoding, and show that each identity word returns its own type bit. Directed sequences use different `drv_intrq` patterns to separate the two channels' enables and to show that closed-window writes leave the enables unchanged. Taskfile and alternate reads and writes use different data on the two `ide_din` buses, so that a wrong channel or a wrong register index becomes visible. Two select values are also applied to confirm the DMA steering.

// File: rtl/ide_dec_pkg.sv
package ide_dec_pkg;

    localparam int NCH  = 2;
    localparam int DA_W = 3;
    localparam int DW   = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_ACK
    } acc_state_e;

    typedef enum logic [2:0] {
        K_NONE,
        K_SEL,
        K_TF,
        K_ALT,
        K_IEN,
        K_STAT,
        K_ID
    } win_kind_e;

    typedef struct packed {
        win_kind_e       kind;
        logic            ch;
        logic [DA_W-1:0] idx;
    } win_hit_t;

endpackage

// File: rtl/ide_addr_decode.sv
module ide_addr_decode
    import ide_dec_pkg::*;
#(
    parameter int ADDR_W   = 14,
    parameter int WIN_BITS = 12,
    parameter int CH0_WIN  = 2,
    parameter int TF_SHIFT = 6,
    parameter int IEN_OFF  = 'h200,
    parameter int STAT_OFF = 'h290,
    parameter int ALT_OFF  = 'h380,
    parameter int ID_OFF   = 'h280,
    parameter int ID_SHIFT = 2,
    parameter int ID_BITS  = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              ext_en,
    output win_hit_t          hit
);

    localparam int HI_W    = ADDR_W - WIN_BITS;
    localparam int TF_SPAN = (1 << DA_W) << TF_SHIFT;
    localparam int ID_SPAN = ID_BITS << ID_SHIFT;

    logic [WIN_BITS-1:0] lo;
    logic [WIN_BITS-1:0] id_rel;
    logic [HI_W-1:0]     hi;
    logic                in_ch;
    logic                ch1;

    always_comb begin
        lo     = addr[WIN_BITS-1:0];
        hi     = addr[ADDR_W-1:WIN_BITS];
        id_rel = lo - WIN_BITS'(ID_OFF);
        in_ch  = (hi == HI_W'(CH0_WIN)) || (hi == HI_W'(CH0_WIN + 1));
        ch1    = (hi == HI_W'(CH0_WIN + 1));

        hit.kind = K_NONE;
        hit.ch   = ch1;
        hit.idx  = '0;

        if (addr == '0) begin
            hit.kind = K_SEL;
        end else if (in_ch && ext_en) begin
            if ((int'(lo) < TF_SPAN) && (lo[TF_SHIFT-1:0] == '0)) begin
                hit.kind = K_TF;
                hit.idx  = lo[TF_SHIFT +: DA_W];
            end else if (lo == WIN_BITS'(IEN_OFF)) begin
                hit.kind = K_IEN;
            end else if (lo == WIN_BITS'(STAT_OFF)) begin
                hit.kind = K_STAT;
            end else if (lo == WIN_BITS'(ALT_OFF)) begin
                hit.kind = K_ALT;
                hit.idx  = DA_W'(6);
            end
        end else if (in_ch && !ch1 && (int'(id_rel) < ID_SPAN)
                     && (id_rel[ID_SHIFT-1:0] == '0)) begin
            hit.kind = K_ID;
            hit.idx  = DA_W'(id_rel >> ID_SHIFT);
        end
    end

endmodule

// File: rtl/ide_irq_ctrl.sv
module ide_irq_ctrl
    import ide_dec_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] en_set,
    input  logic [NCH-1:0] en_clr,
    input  logic [NCH-1:0] intrq,
    output logic [NCH-1:0] en,
    output logic           card_irq
);

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en[g] <= 1'b0;
            end else if (en_set[g]) begin
                en[g] <= 1'b1;
            end else if (en_clr[g]) begin
                en[g] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            card_irq <= 1'b0;
        end else begin
            card_irq <= |(en & intrq);
        end
    end

endmodule

// File: rtl/ide_dma_route.sv
module ide_dma_route
    import ide_dec_pkg::*;
(
    input  logic           sel_ch,
    input  logic [NCH-1:0] drv_dmarq,
    output logic           host_dmarq,
    input  logic           host_dmack,
    output logic [NCH-1:0] drv_dmack
);

    assign host_dmarq = drv_dmarq[sel_ch];

    for (genvar g = 0; g < NCH; g++) begin : g_ack
        assign drv_dmack[g] = host_dmack && (int'(sel_ch) == g);
    end

endmodule

// File: rtl/ide_card_decoder.sv
module ide_card_decoder
    import ide_dec_pkg::*;
#(
    parameter int         ADDR_W      = 14,
    parameter int         SEL_CH_BIT  = 0,
    parameter int         SEL_EXT_BIT = 5,
    parameter logic [3:0] CARD_TYPE   = 4'd3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DW-1:0]     host_wdata,
    output logic              host_ack,
    output logic [DW-1:0]     host_rdata,
    output logic              card_irq,
    input  logic [NCH-1:0]    drv_intrq,
    input  logic [NCH-1:0]    drv_dmarq,
    output logic              host_dmarq,
    input  logic              host_dmack,
    output logic [NCH-1:0]    drv_dmack,
    output logic [NCH-1:0]    ide_cs_tf,
    output logic [NCH-1:0]    ide_cs_alt,
    output logic [DA_W-1:0]   ide_da,
    output logic              ide_rd,
    output logic              ide_wr,
    output logic [DW-1:0]     ide_dout,
    input  logic [DW-1:0]     ide_din0,
    input  logic [DW-1:0]     ide_din1
);

    acc_state_e      state_q, state_d;
    win_hit_t        hit;
    logic            accept;
    logic            to_drive;
    logic            sel_ch_q, sel_ext_q;
    logic            acc_ch, acc_we, acc_alt;
    logic [DA_W-1:0] acc_da;
    logic [DW-1:0]   acc_wdata;
    logic [DW-1:0]   rdata_q;
    logic [DW-1:0]   reg_rdata;
    logic [NCH-1:0]  en_set, en_clr;
    logic [NCH-1:0]  irq_en;

    ide_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr   (host_addr),
        .ext_en (sel_ext_q),
        .hit    (hit)
    );

    ide_irq_ctrl u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_set   (en_set),
        .en_clr   (en_clr),
        .intrq    (drv_intrq),
        .en       (irq_en),
        .card_irq (card_irq)
    );

    ide_dma_route u_dma (
        .sel_ch     (sel_ch_q),
        .drv_dmarq  (drv_dmarq),
        .host_dmarq (host_dmarq),
        .host_dmack (host_dmack),
        .drv_dmack  (drv_dmack)
    );

    assign accept   = (state_q == ST_IDLE) && host_req;
    assign to_drive = (hit.kind == K_TF) || (hit.kind == K_ALT);

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            en_set[c] = accept && (hit.kind == K_IEN) &&  host_we && (int'(hit.ch) == c);
            en_clr[c] = accept && (hit.kind == K_IEN) && !host_we && (int'(hit.ch) == c);
        end
    end

    always_comb begin
        reg_rdata = '1;
        unique case (hit.kind)
            K_SEL: begin
                reg_rdata = '0;
                reg_rdata[SEL_CH_BIT]  = sel_ch_q;
                reg_rdata[SEL_EXT_BIT] = sel_ext_q;
            end
            K_ID:   reg_rdata = {{(DW-1){1'b0}}, CARD_TYPE[hit.idx[1:0]]};
            K_STAT: reg_rdata = {{(DW-1){1'b0}}, drv_intrq[hit.ch]};
            K_IEN:  reg_rdata = '0;
            K_TF, K_ALT, K_NONE: reg_rdata = '1;
            default: reg_rdata = '1;
        endcase
    end

    // Sequencer: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = to_drive ? ST_SETUP : ST_ACK;
            ST_SETUP:  state_d = ST_STROBE;
            ST_STROBE: state_d = ST_ACK;
            ST_ACK:    state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Sequencer: state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Access capture, select register and read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_ch_q  <= 1'b0;
            sel_ext_q <= 1'b0;
            acc_ch    <= 1'b0;
            acc_we    <= 1'b0;
            acc_alt   <= 1'b0;
            acc_da    <= '0;
            acc_wdata <= '0;
            rdata_q   <= '0;
        end else if (accept) begin
            acc_ch    <= hit.ch;
            acc_we    <= host_we;
            acc_alt   <= (hit.kind == K_ALT);
            acc_da    <= hit.idx;
            acc_wdata <= host_wdata;
            rdata_q   <= reg_rdata;
            if ((hit.kind == K_SEL) && host_we) begin
                sel_ch_q  <= host_wdata[SEL_CH_BIT];
                sel_ext_q <= host_wdata[SEL_EXT_BIT];
            end
        end else if ((state_q == ST_STROBE) && !acc_we) begin
            rdata_q <= acc_ch ? ide_din1 : ide_din0;
        end
    end

    // Sequencer: outputs
    always_comb begin
        host_ack   = 1'b0;
        ide_cs_tf  = '0;
        ide_cs_alt = '0;
        ide_da     = '0;
        ide_rd     = 1'b0;
        ide_wr     = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SETUP, ST_STROBE: begin
                if (acc_alt) ide_cs_alt[acc_ch] = 1'b1;
                else         ide_cs_tf[acc_ch]  = 1'b1;
                ide_da = acc_da;
                if (state_q == ST_STROBE) begin
                    ide_rd = !acc_we;
                    ide_wr =  acc_we;
                end
            end
            ST_ACK:  host_ack = 1'b1;
            default: ;
        endcase
    end

    assign host_rdata = rdata_q;
    assign ide_dout   = acc_wdata;

endmodule

// File: rtl/ide_card_decoder_chk.sv
module ide_card_decoder_chk
    import ide_dec_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic           host_ack,
    input logic           card_irq,
    input logic [NCH-1:0] irq_en,
    input logic [NCH-1:0] ide_cs_tf,
    input logic [NCH-1:0] ide_cs_alt,
    input logic           ide_rd,
    input logic           ide_wr,
    input logic [NCH-1:0] drv_dmack
);

    p_ack_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);

    p_irq_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == '0) |=> !card_irq);

    p_single_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ide_cs_tf, ide_cs_alt}));

    p_rdwr_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(ide_rd && ide_wr));

    p_strobe_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ide_rd || ide_wr) |-> ((ide_cs_tf | ide_cs_alt) != '0));

    p_strobe_after_setup_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ide_rd || ide_wr) |-> $stable({ide_cs_tf, ide_cs_alt}));

    p_dmack_route_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(drv_dmack));

endmodule

bind ide_card_decoder ide_card_decoder_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_ack   (host_ack),
    .card_irq   (card_irq),
    .irq_en     (irq_en),
    .ide_cs_tf  (ide_cs_tf),
    .ide_cs_alt (ide_cs_alt),
    .ide_rd     (ide_rd),
    .ide_wr     (ide_wr),
    .drv_dmack  (drv_dmack)
);

// File: tb/ide_card_decoder_tb_top.sv
module ide_card_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_req, host_we;
    logic [13:0] host_addr;
    logic [7:0]  host_wdata;
    logic        host_ack;
    logic [7:0]  host_rdata;
    logic        card_irq;
    logic [1:0]  drv_intrq, drv_dmarq, drv_dmack;
    logic        host_dmarq, host_dmack;
    logic [1:0]  ide_cs_tf, ide_cs_alt;
    logic [2:0]  ide_da;
    logic        ide_rd, ide_wr;
    logic [7:0]  ide_dout, ide_din0, ide_din1;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [3:0] snap_cs [0:7];
    logic       snap_rd [0:7];
    logic       snap_wr [0:7];
    logic [2:0] snap_da [0:7];
    logic [7:0] snap_do [0:7];

    always #5 clk = ~clk;

    ide_card_decoder dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_ack(host_ack), .host_rdata(host_rdata),
        .card_irq(card_irq), .drv_intrq(drv_intrq), .drv_dmarq(drv_dmarq),
        .host_dmarq(host_dmarq), .host_dmack(host_dmack), .drv_dmack(drv_dmack),
        .ide_cs_tf(ide_cs_tf), .ide_cs_alt(ide_cs_alt), .ide_da(ide_da),
        .ide_rd(ide_rd), .ide_wr(ide_wr), .ide_dout(ide_dout),
        .ide_din0(ide_din0), .ide_din1(ide_din1)
    );

    // {we, addr[15:0], wdata, expected, requirement number}; drv_intrq = 2'b10
    localparam int NVEC = 15;
    localparam logic [40:0] VEC [0:NVEC-1] = '{
        {1'b0, 16'h0000, 8'h00, 8'h00, 8'd1},   // R1 select after reset
        {1'b0, 16'h2280, 8'h00, 8'h01, 8'd3},   // R3 type bit 0
        {1'b0, 16'h2284, 8'h00, 8'h01, 8'd3},   // R3 type bit 1
        {1'b0, 16'h2288, 8'h00, 8'h00, 8'd3},   // R3 type bit 2
        {1'b0, 16'h228C, 8'h00, 8'h00, 8'd3},   // R3 type bit 3
        {1'b0, 16'h3290, 8'h00, 8'hFF, 8'd4},   // R4 closed window
        {1'b1, 16'h0000, 8'hFF, 8'h00, 8'd2},   // R2 load select
        {1'b0, 16'h0000, 8'h00, 8'h21, 8'd2},   // R2 readback
        {1'b0, 16'h2280, 8'h00, 8'hFF, 8'd3},   // R3 identity hidden
        {1'b0, 16'h1234, 8'h00, 8'hFF, 8'd11},  // R11 unmapped
        {1'b0, 16'h2010, 8'h00, 8'hFF, 8'd11},  // R11 misaligned taskfile
        {1'b0, 16'h2290, 8'h00, 8'h00, 8'd6},   // R6 channel 0 idle
        {1'b0, 16'h3290, 8'h00, 8'h01, 8'd6},   // R6 channel 1 pending
        {1'b1, 16'h0000, 8'h20, 8'h00, 8'd2},   // R2 window on, channel 0
        {1'b0, 16'h0000, 8'h00, 8'h20, 8'd2}    // R2 readback
    };

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", rq, act, exp);
        end
    endtask

    task automatic snap(input int k);
        snap_cs[k] = {ide_cs_alt, ide_cs_tf};
        snap_rd[k] = ide_rd;
        snap_wr[k] = ide_wr;
        snap_da[k] = ide_da;
        snap_do[k] = ide_dout;
    endtask

    task automatic acc(input logic we, input logic [13:0] a, input logic [7:0] d,
                       output logic [7:0] rd, output int lat);
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_req = 1'b0;
        lat = 1;
        snap(lat);
        while (!host_ack && lat < 7) begin
            @(negedge clk);
            lat++;
            snap(lat);
        end
        rd = host_rdata;
    endtask

    task automatic run_table();
        logic [7:0] rd;
        int lat;
        for (int i = 0; i < NVEC; i++) begin
            logic [40:0] v;
            v = VEC[i];
            acc(v[40], v[37:24], v[23:16], rd, lat);
            if (!v[40]) chk($sformatf("R%0d row %0d", v[7:0], i), rd, v[15:8]);
            chk("R12 register latency", lat, 1);
        end
    endtask

    initial begin
        logic [7:0] rd;
        int lat;
        rst_n = 1'b0; host_req = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
        drv_intrq = 2'b10; drv_dmarq = 2'b00; host_dmack = 1'b0;
        ide_din0 = 8'hA5; ide_din1 = 8'h5A;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 card_irq", card_irq, 0);
        chk("R1 ack", host_ack, 0);
        chk("R1 chip selects", {ide_cs_alt, ide_cs_tf, ide_rd, ide_wr}, 0);

        run_table();

        // R5 / R7 enable and combine
        drv_intrq = 2'b00;
        acc(1'b1, 14'h2200, 8'h00, rd, lat);
        repeat (2) @(negedge clk);
        chk("R7 enabled but idle", card_irq, 0);
        drv_intrq = 2'b01;
        repeat (2) @(negedge clk);
        chk("R5 write sets enable", card_irq, 1);
        acc(1'b0, 14'h2200, 8'h00, rd, lat);
        chk("R5 read value", rd, 8'h00);
        repeat (2) @(negedge clk);
        chk("R5 read clears enable", card_irq, 0);
        drv_intrq = 2'b11;
        acc(1'b1, 14'h3200, 8'h00, rd, lat);
        repeat (2) @(negedge clk);
        chk("R7 channel 1 irq", card_irq, 1);
        acc(1'b0, 14'h2200, 8'h00, rd, lat);
        repeat (2) @(negedge clk);
        chk("R7 other channel unaffected", card_irq, 1);
        acc(1'b0, 14'h3200, 8'h00, rd, lat);
        repeat (2) @(negedge clk);
        chk("R5 channel 1 cleared", card_irq, 0);

        // R4 closed window ignores enable writes
        acc(1'b1, 14'h0000, 8'h00, rd, lat);
        acc(1'b1, 14'h3200, 8'h00, rd, lat);
        chk("R4 no chip select", snap_cs[1], 4'b0000);
        acc(1'b0, 14'h2290, 8'h00, rd, lat);
        chk("R4 status hidden", rd, 8'hFF);
        acc(1'b1, 14'h0000, 8'h20, rd, lat);
        repeat (2) @(negedge clk);
        chk("R4 enable untouched", card_irq, 0);

        // R8 taskfile read, channel 1 register 7
        acc(1'b0, 14'h31C0, 8'h00, rd, lat);
        chk("R12 taskfile latency", lat, 3);
        chk("R8 setup cs", snap_cs[1], 4'b0010);
        chk("R8 setup no strobe", snap_rd[1], 0);
        chk("R8 setup da", snap_da[1], 3'd7);
        chk("R8 strobe cs", snap_cs[2], 4'b0010);
        chk("R8 strobe rd", snap_rd[2], 1);
        chk("R8 ack cs released", snap_cs[3], 4'b0000);
        chk("R8 read data", rd, 8'h5A);

        // R8 taskfile write, channel 0 register 1
        acc(1'b1, 14'h2040, 8'h33, rd, lat);
        chk("R8 write cs", snap_cs[2], 4'b0001);
        chk("R8 write strobe", {snap_wr[2], snap_rd[2]}, 2'b10);
        chk("R8 write da", snap_da[2], 3'd1);
        chk("R8 write data", snap_do[2], 8'h33);

        // R9 alternate control, channel 0
        acc(1'b0, 14'h2380, 8'h00, rd, lat);
        chk("R9 alt cs", snap_cs[2], 4'b0100);
        chk("R9 alt da", snap_da[2], 3'd6);
        chk("R9 alt data", rd, 8'hA5);

        // R10 DMA routing
        drv_dmarq = 2'b10; host_dmack = 1'b1;
        @(negedge clk);
        chk("R10 channel 0 request", host_dmarq, 0);
        chk("R10 channel 0 ack", drv_dmack, 2'b01);
        acc(1'b1, 14'h0000, 8'h21, rd, lat);
        @(negedge clk);
        chk("R10 channel 1 request", host_dmarq, 1);
        chk("R10 channel 1 ack", drv_dmack, 2'b10);
        host_dmack = 1'b0;

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule